// File: doc/BRIEF.md
# Mode-Dependent Aliased Register File

This block holds the programmer-visible registers of a processor core that runs in one of three operating modes: a base compatibility mode, an extended mode and a wide 32-bit mode. The physical storage is four 8-bit accumulator bytes, a V register, five pointer registers (X, Y, U, S, PC), a 16-bit DS register and two 8-bit plain registers (DP, CC). The 16-, 32- and 64-bit accumulators are views built by joining those bytes. A write through any view updates the bytes beneath it, and a read through any view shows the current bytes.

Two read ports and one write port each take a 5-bit register selector and a 2-bit access width. The current mode sets which registers exist and how wide the pointer and V registers are. A read that names a register missing in the current mode, or that uses the wrong width, returns zero. A write of the same kind is dropped. In both cases a one-cycle illegal-access strobe follows. A zero register exists in the two lower modes. It reads as zero and swallows writes.

Top module: `aliased_regfile`

## Requirements
- R1: A synchronous active-high reset clears every stored register to zero. While reset is held, both read outputs and the illegal strobe read zero.
- R2: Read data is registered and appears one clock after the selector is presented. A read and a write to the same register on the same edge return the value from before the write.
- R3: Views read right-justified and zero-extended on the 64-bit bus: D = {A,B}, W = {E,F}, Q = {D,W}, O = {Q,V}, with the first-named part in the upper bits.
- R4: A write through D, W, Q or O updates the bytes beneath it. A single-byte write merges into the views that contain that byte.
- R5: The zero register reads zero and discards writes in base and extended mode. In wide mode it is an illegal access.
- R6: E, F, W, Q and V are illegal in base mode. O and DS are illegal outside wide mode. Selector codes 18 to 31 are always illegal. An illegal read returns zero, an illegal write changes nothing, and either raises the strobe `ill` on the next clock.
- R7: The access width must match the register's width in the current mode, otherwise the access is illegal. The widths are: A, B, E, F, DP, CC 8 bits; D, W, DS 16 bits; Q 32 bits; O 64 bits; X, Y, U, S, PC, V 32 bits in wide mode and 16 bits otherwise. The zero register accepts every width.
- R8: In wide mode the pointer registers and V hold 32 bits. In the lower modes they read zero-extended from 16 bits, and a write stores the low 16 bits with the upper 16 bits zero.
- R9: While the mode is not wide, the upper 16 bits of every pointer register and of V are forced to zero. A wide value does not survive a visit to a lower mode.
- R10: Mode code 00 is base, 01 is extended, 10 and 11 are both wide. Width codes: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Selector codes: 0 zero, 1 A, 2 B, 3 E, 4 F, 5 D, 6 W, 7 Q, 8 O, 9 V, 10 X, 11 Y, 12 U, 13 S, 14 PC, 15 DP, 16 CC, 17 DS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode code |
| ra_sel | input | 5 | Read port A register selector |
| ra_wid | input | 2 | Read port A access width |
| rb_sel | input | 5 | Read port B register selector |
| rb_wid | input | 2 | Read port B access width |
| we | input | 1 | Write enable |
| w_sel | input | 5 | Write register selector |
| w_wid | input | 2 | Write access width |
| w_data | input | 64 | Write data, right-justified |
| ra_data | output | 64 | Read port A data, registered |
| rb_data | output | 64 | Read port B data, registered |
| ill | output | 1 | Illegal-access strobe for the previous cycle |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. That covers read data, the illegal strobe and a write's effect on storage. The bench therefore drives each selector and write on a falling edge and samples one falling edge later. A read that follows a write is issued in the next cycle, so it sees the updated bytes. The same-edge read-during-write case has its own directed test, which expects the old value first and the new value one cycle later. Checks of the mode-dependent clearing of upper halves read the register after the cycle in which the mode changed.

// File: rtl/arf_pkg.sv
package arf_pkg;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 2 * BYTE_W;
  localparam int PTR_W   = 2 * HALF_W;
  localparam int BUS_W   = 2 * PTR_W;
  localparam int NUM_PTR = 5;
  localparam int SEL_W   = 5;
  localparam int NUM_RD  = 2;

  typedef enum logic [SEL_W-1:0] {
    RC_ZR = 5'd0, RC_A = 5'd1, RC_B = 5'd2, RC_E = 5'd3, RC_F = 5'd4,
    RC_D = 5'd5, RC_W = 5'd6, RC_Q = 5'd7, RC_O = 5'd8, RC_V = 5'd9,
    RC_X = 5'd10, RC_Y = 5'd11, RC_U = 5'd12, RC_S = 5'd13, RC_PC = 5'd14,
    RC_DP = 5'd15, RC_CC = 5'd16, RC_DS = 5'd17
  } rcode_e;

  typedef enum logic [1:0] {AW_8 = 2'd0, AW_16 = 2'd1, AW_32 = 2'd2, AW_64 = 2'd3} awid_e;

  typedef struct packed {
    logic [BYTE_W-1:0] a, b, e, f;
    logic [PTR_W-1:0] v;
    logic [NUM_PTR-1:0][PTR_W-1:0] ptr;
    logic [HALF_W-1:0] ds;
    logic [BYTE_W-1:0] dp, cc;
  } arf_state_t;

  function automatic logic mode_wide(input logic [1:0] md);
    return md[1];
  endfunction

  // Legality of one access: register present in this mode and width matching.
  function automatic logic access_ok(input logic [SEL_W-1:0] sel,
                                     input logic [1:0] wid,
                                     input logic [1:0] md);
    logic wide, base;
    logic [1:0] pw;
    wide = md[1];
    base = (md == 2'b00);
    pw   = wide ? AW_32 : AW_16;
    case (sel)
      RC_ZR:                         return !wide;
      RC_A, RC_B, RC_DP, RC_CC:      return wid == AW_8;
      RC_E, RC_F:                    return !base && wid == AW_8;
      RC_D:                          return wid == AW_16;
      RC_W:                          return !base && wid == AW_16;
      RC_Q:                          return !base && wid == AW_32;
      RC_O:                          return wide && wid == AW_64;
      RC_V:                          return !base && wid == pw;
      RC_X, RC_Y, RC_U, RC_S, RC_PC: return wid == pw;
      RC_DS:                         return wide && wid == AW_16;
      default:                       return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/arf_access_check.sv
module arf_access_check
  import arf_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       wid,
  input  logic [1:0]       mode,
  output logic             ok
);
  assign ok = access_ok(sel, wid, mode);
endmodule

// File: rtl/arf_store.sv
module arf_store
  import arf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             we,
  input  logic             w_ok,
  input  logic [SEL_W-1:0] w_sel,
  input  logic [BUS_W-1:0] w_data,
  output arf_state_t       st
);
  localparam int UP_W = PTR_W - HALF_W;

  logic             wide;
  logic [2:0]       pidx;
  logic [PTR_W-1:0] wptr;

  assign wide = mode_wide(mode);
  assign pidx = 3'(w_sel - RC_X);
  assign wptr = wide ? w_data[PTR_W-1:0] : {{UP_W{1'b0}}, w_data[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      if (!wide) begin
        st.v[PTR_W-1:HALF_W] <= '0;
        for (int i = 0; i < NUM_PTR; i++) st.ptr[i][PTR_W-1:HALF_W] <= '0;
      end
      if (we && w_ok) begin
        case (w_sel)
          RC_A:  st.a <= w_data[BYTE_W-1:0];
          RC_B:  st.b <= w_data[BYTE_W-1:0];
          RC_E:  st.e <= w_data[BYTE_W-1:0];
          RC_F:  st.f <= w_data[BYTE_W-1:0];
          RC_D:  {st.a, st.b} <= w_data[HALF_W-1:0];
          RC_W:  {st.e, st.f} <= w_data[HALF_W-1:0];
          RC_Q:  {st.a, st.b, st.e, st.f} <= w_data[PTR_W-1:0];
          RC_O:  {st.a, st.b, st.e, st.f, st.v} <= w_data;
          RC_V:  st.v <= wptr;
          RC_X, RC_Y, RC_U, RC_S, RC_PC: st.ptr[pidx] <= wptr;
          RC_DS: st.ds <= w_data[HALF_W-1:0];
          RC_DP: st.dp <= w_data[BYTE_W-1:0];
          RC_CC: st.cc <= w_data[BYTE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  a_r4_d_view_write: assert property (@(posedge clk) disable iff (rst)
    (we && w_ok && w_sel == RC_D) |=> (st.a == $past(w_data[15:8]) && st.b == $past(w_data[7:0])));

  a_r5_zero_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (we && w_sel == RC_ZR) |=> ({st.a, st.b, st.e, st.f, st.ds, st.dp, st.cc} ==
                                $past({st.a, st.b, st.e, st.f, st.ds, st.dp, st.cc})));

  a_r6_illegal_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (we && !w_ok) |=> ({st.a, st.b, st.e, st.f, st.ds, st.dp, st.cc} ==
                       $past({st.a, st.b, st.e, st.f, st.ds, st.dp, st.cc})));

  a_r9_v_upper_held: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (st.v[PTR_W-1:HALF_W] == '0));

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr_chk
    a_r9_ptr_upper_held: assert property (@(posedge clk) disable iff (rst)
      !wide |=> (st.ptr[g][PTR_W-1:HALF_W] == '0));
  end
endmodule

// File: rtl/arf_read_port.sv
module arf_read_port
  import arf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             ok,
  input  arf_state_t       st,
  output logic [BUS_W-1:0] data_q,
  output logic             ill_q
);
  logic             wide;
  logic [2:0]       pidx;
  logic [PTR_W-1:0] pval, vval;
  logic [BUS_W-1:0] view;

  assign wide = mode_wide(mode);
  assign pidx = 3'(sel - RC_X);
  assign pval = wide ? st.ptr[pidx] : {{(PTR_W-HALF_W){1'b0}}, st.ptr[pidx][HALF_W-1:0]};
  assign vval = wide ? st.v : {{(PTR_W-HALF_W){1'b0}}, st.v[HALF_W-1:0]};

  always_comb begin
    view = '0;
    case (sel)
      RC_A:  view = BUS_W'(st.a);
      RC_B:  view = BUS_W'(st.b);
      RC_E:  view = BUS_W'(st.e);
      RC_F:  view = BUS_W'(st.f);
      RC_D:  view = BUS_W'({st.a, st.b});
      RC_W:  view = BUS_W'({st.e, st.f});
      RC_Q:  view = BUS_W'({st.a, st.b, st.e, st.f});
      RC_O:  view = {st.a, st.b, st.e, st.f, st.v};
      RC_V:  view = BUS_W'(vval);
      RC_X, RC_Y, RC_U, RC_S, RC_PC: view = BUS_W'(pval);
      RC_DS: view = BUS_W'(st.ds);
      RC_DP: view = BUS_W'(st.dp);
      RC_CC: view = BUS_W'(st.cc);
      default: view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      data_q <= ok ? view : '0;
      ill_q  <= !ok;
    end
  end

  a_r5_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (sel == RC_ZR && !mode[1]) |=> (data_q == '0 && !ill_q));

  a_r8_ptr_zero_extended: assert property (@(posedge clk) disable iff (rst)
    (!mode[1] && sel >= RC_X && sel <= RC_PC) |=> (data_q[BUS_W-1:HALF_W] == '0));
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile
  import arf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic [4:0]           ra_sel,
  input  logic [1:0]           ra_wid,
  input  logic [4:0]           rb_sel,
  input  logic [1:0]           rb_wid,
  input  logic                 we,
  input  logic [4:0]           w_sel,
  input  logic [1:0]           w_wid,
  input  logic [63:0]          w_data,
  output logic [63:0]          ra_data,
  output logic [63:0]          rb_data,
  output logic                 ill
);
  arf_state_t              st;
  logic                    w_ok, w_ill_q;
  logic [SEL_W-1:0]        rsel [NUM_RD];
  logic [1:0]              rwid [NUM_RD];
  logic [BUS_W-1:0]        rdat [NUM_RD];
  logic [NUM_RD-1:0]       rok, rill;

  assign rsel[0] = ra_sel;
  assign rsel[1] = rb_sel;
  assign rwid[0] = ra_wid;
  assign rwid[1] = rb_wid;

  arf_access_check u_wchk (.sel(w_sel), .wid(w_wid), .mode(mode), .ok(w_ok));

  arf_store u_store (
    .clk(clk), .rst(rst), .mode(mode), .we(we), .w_ok(w_ok),
    .w_sel(w_sel), .w_data(w_data), .st(st)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    arf_access_check u_chk (.sel(rsel[p]), .wid(rwid[p]), .mode(mode), .ok(rok[p]));
    arf_read_port u_port (
      .clk(clk), .rst(rst), .mode(mode), .sel(rsel[p]), .ok(rok[p]),
      .st(st), .data_q(rdat[p]), .ill_q(rill[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) w_ill_q <= 1'b0;
    else     w_ill_q <= we && !w_ok;
  end

  assign ra_data = rdat[0];
  assign rb_data = rdat[1];
  assign ill     = w_ill_q || (|rill);

  a_r6_strobe_after_bad_write: assert property (@(posedge clk) disable iff (rst)
    (we && !w_ok) |=> ill);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (ra_data == '0 && rb_data == '0 && !ill));
endmodule

// File: tb/sim_aliased_regfile.sv
module sim_aliased_regfile;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b01;
  logic [4:0] ra_sel = 5'd1, rb_sel = 5'd1, w_sel = 5'd0;
  logic [1:0] ra_wid = 2'd0, rb_wid = 2'd0, w_wid = 2'd0;
  logic we = 1'b0;
  logic [63:0] w_data = '0;
  logic [63:0] ra_data, rb_data;
  logic ill;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aliased_regfile u0 (
    .clk(clk), .rst(rst), .mode(mode), .ra_sel(ra_sel), .ra_wid(ra_wid),
    .rb_sel(rb_sel), .rb_wid(rb_wid), .we(we), .w_sel(w_sel), .w_wid(w_wid),
    .w_data(w_data), .ra_data(ra_data), .rb_data(rb_data), .ill(ill)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic        wr;
    logic [4:0]  sel;
    logic [1:0]  wid;
    logic [63:0] dat;
    logic [63:0] exp;
    logic        bad;
  } vec_t;

  localparam int NV = 41;
  // mode, write?, selector, width, write data, expected read, expected strobe
  localparam vec_t VT [NV] = '{
    '{2'd1, 1'b1, 5'd5,  2'd1, 64'h1234, 64'h0, 1'b0},             // R4 write D
    '{2'd1, 1'b0, 5'd1,  2'd0, 64'h0, 64'h12, 1'b0},               // R4 A
    '{2'd1, 1'b0, 5'd2,  2'd0, 64'h0, 64'h34, 1'b0},               // R4 B
    '{2'd1, 1'b1, 5'd6,  2'd1, 64'hABCD, 64'h0, 1'b0},             // R4 write W
    '{2'd1, 1'b0, 5'd7,  2'd2, 64'h0, 64'h1234ABCD, 1'b0},         // R3 Q
    '{2'd1, 1'b1, 5'd4,  2'd0, 64'h77, 64'h0, 1'b0},               // R4 write F
    '{2'd1, 1'b0, 5'd6,  2'd1, 64'h0, 64'hAB77, 1'b0},             // R4 merge
    '{2'd1, 1'b0, 5'd0,  2'd0, 64'h0, 64'h0, 1'b0},                // R5 zero reg
    '{2'd1, 1'b1, 5'd0,  2'd1, 64'hFFFF, 64'h0, 1'b0},             // R5 write zero
    '{2'd1, 1'b0, 5'd5,  2'd1, 64'h0, 64'h1234, 1'b0},             // R5 discarded
    '{2'd0, 1'b0, 5'd3,  2'd0, 64'h0, 64'h0, 1'b1},                // R6 E in base
    '{2'd0, 1'b1, 5'd3,  2'd0, 64'h55, 64'h0, 1'b1},               // R6 write E base
    '{2'd1, 1'b0, 5'd3,  2'd0, 64'h0, 64'hAB, 1'b0},               // R6 E kept
    '{2'd1, 1'b0, 5'd5,  2'd0, 64'h0, 64'h0, 1'b1},                // R7 D as byte
    '{2'd1, 1'b0, 5'd0,  2'd3, 64'h0, 64'h0, 1'b0},                // R7 zero any width
    '{2'd2, 1'b1, 5'd8,  2'd3, 64'h0102030405060708, 64'h0, 1'b0}, // R4 write O
    '{2'd2, 1'b0, 5'd8,  2'd3, 64'h0, 64'h0102030405060708, 1'b0}, // R3 O
    '{2'd2, 1'b0, 5'd9,  2'd2, 64'h0, 64'h05060708, 1'b0},         // R3 V
    '{2'd2, 1'b0, 5'd5,  2'd1, 64'h0, 64'h0102, 1'b0},             // R3 D
    '{2'd2, 1'b0, 5'd0,  2'd0, 64'h0, 64'h0, 1'b1},                // R5 zero in wide
    '{2'd2, 1'b1, 5'd10, 2'd2, 64'hDEADBEEF, 64'h0, 1'b0},         // R8 write X
    '{2'd2, 1'b0, 5'd10, 2'd2, 64'h0, 64'hDEADBEEF, 1'b0},         // R8 X wide
    '{2'd1, 1'b0, 5'd10, 2'd1, 64'h0, 64'hBEEF, 1'b0},             // R8 X narrow
    '{2'd2, 1'b0, 5'd10, 2'd2, 64'h0, 64'h0000BEEF, 1'b0},         // R9 upper lost
    '{2'd1, 1'b0, 5'd10, 2'd2, 64'h0, 64'h0, 1'b1},                // R7 X word in ext
    '{2'd0, 1'b1, 5'd11, 2'd1, 64'hFFFF4321, 64'h0, 1'b0},         // R8 write Y base
    '{2'd0, 1'b0, 5'd11, 2'd1, 64'h0, 64'h4321, 1'b0},             // R8 Y base
    '{2'd0, 1'b0, 5'd8,  2'd3, 64'h0, 64'h0, 1'b1},                // R6 O in base
    '{2'd1, 1'b0, 5'd17, 2'd1, 64'h0, 64'h0, 1'b1},                // R6 DS in ext
    '{2'd2, 1'b1, 5'd17, 2'd1, 64'h9999, 64'h0, 1'b0},             // R6 write DS
    '{2'd2, 1'b0, 5'd17, 2'd1, 64'h0, 64'h9999, 1'b0},             // R6 DS wide
    '{2'd1, 1'b1, 5'd9,  2'd1, 64'h2468, 64'h0, 1'b0},             // R8 write V ext
    '{2'd1, 1'b0, 5'd9,  2'd1, 64'h0, 64'h2468, 1'b0},             // R8 V ext
    '{2'd2, 1'b0, 5'd9,  2'd2, 64'h0, 64'h00002468, 1'b0},         // R9 V upper
    '{2'd2, 1'b0, 5'd20, 2'd0, 64'h0, 64'h0, 1'b1},                // R6 bad code
    '{2'd3, 1'b0, 5'd8,  2'd3, 64'h0, 64'h0102030400002468, 1'b0}, // R10 mode 11
    '{2'd2, 1'b1, 5'd16, 2'd0, 64'h5A, 64'h0, 1'b0},               // R10 write CC
    '{2'd2, 1'b0, 5'd16, 2'd0, 64'h0, 64'h5A, 1'b0},               // R10 CC
    '{2'd0, 1'b1, 5'd15, 2'd0, 64'h3C, 64'h0, 1'b0},               // R10 write DP
    '{2'd0, 1'b0, 5'd15, 2'd0, 64'h0, 64'h3C, 1'b0},               // R10 DP
    '{2'd2, 1'b0, 5'd14, 2'd2, 64'h0, 64'h0, 1'b0}                 // R8 PC untouched
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    we = 1'b0;
    ra_sel = 5'd1; ra_wid = 2'd0; rb_sel = 5'd1; rb_wid = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset ra_data", ra_data, 64'h0);
    chk("R1 reset rb_data", rb_data, 64'h0);
    chk("R1 reset ill", {63'h0, ill}, 64'h0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: read-during-write returns old value, new value one cycle later
    mode = 2'b01;
    we = 1'b1; w_sel = 5'd5; w_wid = 2'd1; w_data = 64'hCAFE;
    ra_sel = 5'd5; ra_wid = 2'd1; rb_sel = 5'd2; rb_wid = 2'd0;
    @(negedge clk);
    we = 1'b0;
    chk("R2 same-edge read A", ra_data, 64'h0);
    chk("R2 same-edge read B", rb_data, 64'h0);
    @(negedge clk);
    chk("R2 next read A", ra_data, 64'hCAFE);
    chk("R2 next read B", rb_data, 64'hFE);
    chk("R2 no strobe", {63'h0, ill}, 64'h0);
    rb_sel = 5'd1;

    for (int i = 0; i < NV; i++) begin
      mode = VT[i].md;
      if (VT[i].wr) begin
        we = 1'b1; w_sel = VT[i].sel; w_wid = VT[i].wid; w_data = VT[i].dat;
        ra_sel = 5'd1; ra_wid = 2'd0;
      end else begin
        ra_sel = VT[i].sel; ra_wid = VT[i].wid;
      end
      @(negedge clk);
      we = 1'b0;
      if (!VT[i].wr) chk($sformatf("vector %0d data", i), ra_data, VT[i].exp);
      chk($sformatf("vector %0d strobe", i), {63'h0, ill}, {63'h0, VT[i].bad});
    end

    // R1: reset mid-run clears storage
    do_reset();
    mode = 2'b10; ra_sel = 5'd8; ra_wid = 2'd3;
    @(negedge clk);
    chk("R1 O cleared by reset", ra_data, 64'h0);
    chk("R1 strobe after reset", {63'h0, ill}, 64'h0);

    // R6 strobe is one cycle: legal access right after an illegal one
    ra_sel = 5'd20; ra_wid = 2'd0;
    @(negedge clk);
    chk("R6 strobe raised", {63'h0, ill}, 64'h1);
    ra_sel = 5'd1;
    @(negedge clk);
    chk("R6 strobe drops", {63'h0, ill}, 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule